// File: doc/BRIEF.md
# DMA Sample Counter with Interrupt

This block counts audio samples moved by a DMA transfer engine and raises an interrupt once a programmed number of them has gone by. The host sets a 16-bit base count by writing it as two separate bytes through a small register port. The counter that actually runs is hidden from the host. It picks up the base value only when the upper byte is written. After that it steps down by one for every sample strobe from the transfer engine, no matter how many bytes each sample holds.

The interrupt event is an underflow: a sample arrives while the counter already reads zero. A base value of N therefore yields one event every N+1 samples. On underflow the counter reloads itself from the base registers, so a continuous transfer runs without the host stepping in. The event sets a status flag that the host can always read. The external interrupt pin shows that flag only while an enable bit is set. The host clears the flag by writing to the status register.

Top module: `dma_sample_irq`

## Requirements
- R1: The base low byte (address 0) and base high byte (address 1) are written separately, and a read returns the last value written to each. A read never returns the live count.
- R2: A write to address 1 loads the counter, on that clock edge, with the written byte as its upper half and the stored low byte as its lower half.
- R3: A write to address 0 alone leaves the counter unchanged.
- R4: Each sample strobe while the counter is nonzero lowers the counter by exactly one. One strobe stands for one whole sample.
- R5: A strobe while the counter is zero is an underflow. It sets the interrupt flag on that edge, so a base of N raises the flag on the (N+1)th strobe.
- R6: Status (address 2) bit 0 reads the interrupt flag whether or not interrupts are enabled.
- R7: The interrupt pin is high only when both the enable bit and the flag are set. The enable bit is config (address 3) bit 0, written from data bit 0.
- R8: On underflow the counter reloads from the base registers as they stood before that edge, and counting continues.
- R9: Any write to address 2 clears the flag. An underflow in the same cycle wins, and the flag stays set.
- R10: When a write to address 1 and a strobe fall in the same cycle, the reload wins. That strobe neither decrements the counter nor raises an event.
- R11: Reset asserts asynchronously and releases on the second clock edge after rst_n rises. It clears both base bytes, the counter, the flag and the enable bit.
- R12: Bits 7 to 1 of the status and config registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 2 | Register address: 0 base low, 1 base high, 2 status, 3 config |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for host_addr, combinational |
| sample_stb | input | 1 | One-cycle pulse per completed sample transfer |
| irq_pin | output | 1 | External interrupt, active high |

## Verification
Every register result (base bytes, enable, counter and flag) changes on the clock edge that samples the write or strobe. Read data and the pin follow those registers with no further delay. Each bench step drives its inputs at a falling edge and lets one rising edge pass. It then reads one register and the pin just after the next falling edge, so every result is due exactly one edge after its stimulus. The hidden counter is judged only through when the flag rises, against a bench model that updates at the same edge. After reset release, the bench waits past the two-edge synchronizer before its first check.

// File: rtl/smc_pkg.sv
package smc_pkg;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CFG  = 2'd2,
    SEL_NONE = 2'd3
  } smc_sel_e;

  function automatic smc_sel_e smc_decode(input int unsigned addr, input int unsigned nbytes);
    if (addr < nbytes)
      return SEL_BASE;
    else if (addr == nbytes)
      return SEL_STAT;
    else if (addr == nbytes + 1)
      return SEL_CFG;
    else
      return SEL_NONE;
  endfunction

endpackage

// File: rtl/smc_rst_sync.sv
module smc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sync_q <= '0;
    else
      sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/smc_host_regs.sv
module smc_host_regs
  import smc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              flag,
  output logic [BYTE_W-1:0] rdata,
  output logic [CNT_W-1:0]  base_val,
  output logic [CNT_W-1:0]  load_val,
  output logic              irq_en,
  output logic              reload_req,
  output logic              stat_clr
);

  localparam int NB = CNT_W / BYTE_W;
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(NB - 1);

  smc_sel_e sel;
  logic [BYTE_W-1:0] base_q [NB];

  always_comb begin
    sel = smc_decode(int'(addr), NB);
  end

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_byte
      logic              byte_en;
      logic [BYTE_W-1:0] byte_d;

      always_comb begin
        byte_en = wr_en && (addr == ADDR_W'(g));
        byte_d  = byte_en ? wdata : base_q[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          base_q[g] <= '0;
        else
          base_q[g] <= byte_d;
      end

      assign base_val[g*BYTE_W +: BYTE_W] = base_q[g];

      if (g == NB - 1) begin : g_top
        assign load_val[g*BYTE_W +: BYTE_W] = wdata;
      end else begin : g_low
        assign load_val[g*BYTE_W +: BYTE_W] = base_q[g];
      end
    end
  endgenerate

  logic ien_q;
  logic ien_d;
  logic ien_en;

  always_comb begin
    ien_en = wr_en && (sel == SEL_CFG);
    ien_d  = ien_en ? wdata[0] : ien_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ien_q <= 1'b0;
    else
      ien_q <= ien_d;
  end

  assign irq_en     = ien_q;
  assign reload_req = wr_en && (addr == TOP_ADDR);
  assign stat_clr   = wr_en && (sel == SEL_STAT);

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_BASE: begin
        for (int i = 0; i < NB; i++)
          if (addr == ADDR_W'(i))
            rdata = base_q[i];
      end
      SEL_STAT: rdata = {{(BYTE_W-1){1'b0}}, flag};
      SEL_CFG:  rdata = {{(BYTE_W-1){1'b0}}, ien_q};
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/smc_count.sv
module smc_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_stb,
  input  logic             reload_req,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] base_val,
  output logic             underflow,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             is_zero;

  always_comb begin
    is_zero   = (cnt_q == '0);
    underflow = sample_stb && is_zero && !reload_req;
    cnt_en    = reload_req || sample_stb;
    cnt_d     = cnt_q;
    if (cnt_en) begin
      if (reload_req)
        cnt_d = load_val;
      else if (is_zero)
        cnt_d = base_val;
      else
        cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/smc_irq.sv
module smc_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic underflow,
  input  logic stat_clr,
  input  logic irq_en,
  output logic flag,
  output logic pin
);

  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (underflow)
      flag_d = 1'b1;
    else if (stat_clr)
      flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else
      flag_q <= flag_d;
  end

  assign flag = flag_q;
  assign pin  = flag_q & irq_en;

endmodule

// File: rtl/dma_sample_irq.sv
module dma_sample_irq #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = $clog2(CNT_W / BYTE_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  input  logic              sample_stb,
  output logic              irq_pin
);

  logic             rst_sync_n;
  logic [CNT_W-1:0] base_val;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cur_cnt;
  logic             irq_en;
  logic             irq_flag;
  logic             reload_req;
  logic             stat_clr;
  logic             underflow;

  smc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  smc_host_regs #(
    .CNT_W  (CNT_W),
    .BYTE_W (BYTE_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (host_wr),
    .addr       (host_addr),
    .wdata      (host_wdata),
    .flag       (irq_flag),
    .rdata      (host_rdata),
    .base_val   (base_val),
    .load_val   (load_val),
    .irq_en     (irq_en),
    .reload_req (reload_req),
    .stat_clr   (stat_clr)
  );

  smc_count #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sample_stb (sample_stb),
    .reload_req (reload_req),
    .load_val   (load_val),
    .base_val   (base_val),
    .underflow  (underflow),
    .cnt        (cur_cnt)
  );

  smc_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .underflow (underflow),
    .stat_clr  (stat_clr),
    .irq_en    (irq_en),
    .flag      (irq_flag),
    .pin       (irq_pin)
  );

endmodule

// File: rtl/dma_sample_irq_chk.sv
module dma_sample_irq_chk #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              host_wr,
  input logic [ADDR_W-1:0] host_addr,
  input logic [BYTE_W-1:0] host_wdata,
  input logic              sample_stb,
  input logic              irq_pin,
  input logic              irq_flag,
  input logic              irq_en,
  input logic [CNT_W-1:0]  cur_cnt,
  input logic [CNT_W-1:0]  base_val
);

  localparam int NB = CNT_W / BYTE_W;
  localparam logic [ADDR_W-1:0] HI_A   = ADDR_W'(NB - 1);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(NB);

  logic hi_wr;
  logic lo_wr;
  logic uf_now;

  assign hi_wr  = host_wr && (host_addr == HI_A);
  assign lo_wr  = host_wr && (host_addr < HI_A);
  assign uf_now = sample_stb && (cur_cnt == '0) && !hi_wr;

  assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hi_wr |=> cur_cnt == {$past(host_wdata), $past(base_val[CNT_W-BYTE_W-1:0])});

  assert_low_no_load_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lo_wr && !sample_stb) |=> $stable(cur_cnt));

  assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sample_stb && !hi_wr && cur_cnt != '0) |=> cur_cnt == $past(cur_cnt) - CNT_W'(1));

  assert_underflow_flag_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    uf_now |=> irq_flag);

  assert_pin_gated_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !irq_en |-> !irq_pin);

  assert_underflow_reload_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    uf_now |=> cur_cnt == $past(base_val));

  assert_clear_priority_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_wr && host_addr == STAT_A && !uf_now) |=> !irq_flag);

  assert_reload_wins_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hi_wr && sample_stb && !irq_flag && !(host_wr && host_addr == STAT_A)) |=> !irq_flag);

endmodule

bind dma_sample_irq dma_sample_irq_chk #(
  .CNT_W  (CNT_W),
  .BYTE_W (BYTE_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .host_wr    (host_wr),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .sample_stb (sample_stb),
  .irq_pin    (irq_pin),
  .irq_flag   (irq_flag),
  .irq_en     (irq_en),
  .cur_cnt    (cur_cnt),
  .base_val   (base_val)
);

// File: tb/sim_dma_sample_irq.sv
module sim_dma_sample_irq;

  logic       clk;
  logic       rst_n;
  logic       host_wr;
  logic [1:0] host_addr;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic       sample_stb;
  logic       irq_pin;

  int n_cmp;
  int n_bad;
  bit done;

  logic [7:0]  m_lo;
  logic [7:0]  m_hi;
  logic [15:0] m_cnt;
  logic        m_flag;
  logic        m_ien;

  dma_sample_irq u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .sample_stb (sample_stb),
    .irq_pin    (irq_pin)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return m_lo;
      2'd1:    return m_hi;
      2'd2:    return {7'b0, m_flag};
      default: return {7'b0, m_ien};
    endcase
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit wr, input logic [1:0] a, input logic [7:0] d,
                      input bit stb, input logic [1:0] ra, input string req);
    bit          reload;
    bit          uf;
    logic [15:0] nxt;
    host_wr    = wr;
    host_addr  = a;
    host_wdata = d;
    sample_stb = stb;
    @(posedge clk);
    reload = wr && (a == 2'd1);
    uf     = stb && (m_cnt == 16'd0) && !reload;
    if (reload)     nxt = {d, m_lo};
    else if (uf)    nxt = {m_hi, m_lo};
    else if (stb)   nxt = m_cnt - 16'd1;
    else            nxt = m_cnt;
    m_cnt = nxt;
    if (uf)                      m_flag = 1'b1;
    else if (wr && a == 2'd2)    m_flag = 1'b0;
    if (wr && a == 2'd0) m_lo  = d;
    if (wr && a == 2'd1) m_hi  = d;
    if (wr && a == 2'd3) m_ien = d[0];
    @(negedge clk);
    host_wr    = 1'b0;
    sample_stb = 1'b0;
    host_addr  = ra;
    #1;
    check(host_rdata, exp_read(ra), req);
    check({7'b0, irq_pin}, {7'b0, m_flag & m_ien}, {req, " R7 pin"});
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5a17));
    n_cmp = 0; n_bad = 0; done = 0;
    m_lo = 0; m_hi = 0; m_cnt = 0; m_flag = 0; m_ien = 0;
    host_wr = 0; host_addr = 0; host_wdata = 0; sample_stb = 0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state, R12 upper bits zero
    for (int a = 0; a < 4; a++) begin
      host_addr = 2'(a);
      #1;
      check(host_rdata, 8'h00, "R11 reset R12");
    end
    check({7'b0, irq_pin}, 8'h00, "R11 pin");

    // R1 / R2 program base 3
    step(1, 2'd0, 8'h03, 0, 2'd0, "R1 low readback");
    step(1, 2'd1, 8'h00, 0, 2'd1, "R1 R2 high readback");
    step(1, 2'd3, 8'hFF, 0, 2'd3, "R12 config bit0 only");
    // R4 three decrements, no event
    for (int i = 0; i < 3; i++) step(0, 2'd0, 8'h00, 1, 2'd2, "R4 no event yet");
    // R5 fourth strobe underflows
    step(0, 2'd0, 8'h00, 1, 2'd2, "R5 underflow flag");
    // R6 disable: status still set, pin low
    step(1, 2'd3, 8'h00, 0, 2'd2, "R6 status independent");
    // R9 clear
    step(1, 2'd2, 8'h00, 0, 2'd2, "R9 clear");
    step(1, 2'd3, 8'h01, 0, 2'd3, "R7 enable");
    // R8 reload after underflow: 3 more then event on 4th
    for (int i = 0; i < 3; i++) step(0, 2'd0, 8'h00, 1, 2'd2, "R8 reload period");
    step(0, 2'd0, 8'h00, 1, 2'd2, "R8 second underflow");
    step(1, 2'd2, 8'h00, 0, 2'd2, "R9 clear");
    // R3 low write does not reload: counter now 3, write low 9, event after 4 strobes
    step(1, 2'd0, 8'h09, 0, 2'd0, "R3 low write");
    for (int i = 0; i < 3; i++) step(0, 2'd0, 8'h00, 1, 2'd2, "R3 counter kept");
    step(0, 2'd0, 8'h00, 1, 2'd2, "R3 underflow on old count");
    // R9 clear with simultaneous underflow: load zero then clear+strobe
    step(1, 2'd0, 8'h00, 0, 2'd0, "R1 low zero");
    step(1, 2'd1, 8'h00, 0, 2'd2, "R2 load zero");
    step(1, 2'd2, 8'h00, 1, 2'd2, "R9 underflow wins");
    step(1, 2'd2, 8'h00, 0, 2'd2, "R9 clear");
    // R10 high write with strobe while counter zero: reload wins, no event
    step(1, 2'd1, 8'h00, 1, 2'd2, "R10 reload wins");
    step(0, 2'd0, 8'h00, 1, 2'd2, "R10 next strobe underflows");
    step(1, 2'd2, 8'h00, 0, 2'd2, "R9 clear");
    // R2 upper byte: base 0x0100, event on strobe 257
    step(1, 2'd1, 8'h01, 0, 2'd1, "R2 high byte");
    for (int i = 0; i < 256; i++) step(0, 2'd0, 8'h00, 1, 2'd2, "R2 R4 wide count");
    step(0, 2'd0, 8'h00, 1, 2'd2, "R5 wide underflow");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      bit          wr;
      logic [1:0]  a;
      logic [7:0]  d;
      r  = $urandom % 100;
      wr = (r < 20);
      a  = 2'($urandom % 4);
      d  = (a == 2'd1) ? 8'($urandom % 2) : 8'($urandom % 8);
      if (a == 2'd3) d = 8'($urandom);
      step(wr, a, d, ($urandom % 100) < 70, 2'($urandom % 4), "random");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule